// File: doc/BRIEF.md
# Element-wise Vector Multiply Accelerator

This block multiplies two eight-element vectors of 32-bit words, one element by one element, and writes the eight products back to memory. Software sets it up through a small AXI4-Lite register slave. It writes three word-aligned base addresses (first operand, second operand, destination) and sets the interrupt enables. It then writes the start bit. The block then works through a fixed schedule. It fetches the first operand with one 8-beat AXI4 read burst, then the second operand with another 8-beat burst. It multiplies the buffered elements two at a time on two shared multipliers over four cycles. Finally it sends the eight products out in one 8-beat write burst.

A run ends when the write response is accepted. At that point the done and idle flags rise and, if enabled, a level interrupt is raised. A bad read or write response does not stop the run. It sets a sticky error flag that software can read.

Register map (byte offsets on the 6-bit control address): 0x00 control/status, 0x04 global interrupt gate, 0x08 interrupt enable, 0x0C interrupt status, 0x10 first-operand base, 0x18 second-operand base, 0x20 destination base. Control/status bits: bit0 start (write) / busy (read), bit1 done, bit2 idle, bit3 error, bit7 auto-restart request (accepted on write, no effect, reads 0).

Top module: `vmul_accel`

## Requirements
- R1: After reset the control/status register reads 0x00000004 (idle only), `irq` is low, and neither `mem_arvalid` nor `mem_awvalid` is asserted.
- R2: Writing 1 to control bit0 with `cfg_wstrb[0]` set while idle starts a run. Destination word i becomes the low 32 bits of A[i] * B[i] for i = 0..7. The operand words in memory are left unchanged.
- R3: A run issues exactly two read requests: the first-operand base first, then the second-operand base. Each request has `mem_arlen` = 7, `mem_arsize` = 2 and `mem_arburst` = 2'b01 (incrementing). Each address has its low 2 bits forced to 0.
- R4: A run issues one write burst at the destination base, with `mem_awlen` = 7. It carries 8 beats, all with `mem_wstrb` = 4'hF, and `mem_wlast` is high on the eighth beat only.
- R5: Done (bit1) and idle (bit2) rise only after the write response is accepted. A read of the control/status register clears done, so the next read returns 0x00000004.
- R6: A start written while a run is in progress is ignored. A run still produces exactly two read requests and one write request in total.
- R7: Setting bit7 together with start begins one run and no further run follows. Bit7 reads back as 0.
- R8: `irq` equals global gate bit0 AND interrupt-status bit0. Status bit0 is set at run completion when enable bit0 is 1. Writing 1 to status bit0 clears it.
- R9: A non-zero `mem_rresp` or `mem_bresp` during a run still completes the run with correct data movement and sets error bit3. Bit3 is cleared by the next start.
- R10: If run completion and a control/status read are accepted in the same cycle, that read returns 0x00000001 (busy). Done is still set afterwards, so the next read returns 0x00000006.
- R11: The base registers honour the byte strobes and read back with their low 2 bits as 0.
- R12: The write request is presented in the fifth cycle after the cycle of the last second-operand read beat. The four cycles between are the compute steps, each covering two elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_awvalid | input | 1 | Control write address valid |
| cfg_awready | output | 1 | Control write address ready |
| cfg_awaddr | input | 6 | Control write byte address |
| cfg_wvalid | input | 1 | Control write data valid |
| cfg_wready | output | 1 | Control write data ready |
| cfg_wdata | input | 32 | Control write data |
| cfg_wstrb | input | 4 | Control write byte strobes |
| cfg_bvalid | output | 1 | Control write response valid |
| cfg_bready | input | 1 | Control write response ready |
| cfg_bresp | output | 2 | Control write response (always OKAY) |
| cfg_arvalid | input | 1 | Control read address valid |
| cfg_arready | output | 1 | Control read address ready |
| cfg_araddr | input | 6 | Control read byte address |
| cfg_rvalid | output | 1 | Control read data valid |
| cfg_rready | input | 1 | Control read data ready |
| cfg_rdata | output | 32 | Control read data |
| cfg_rresp | output | 2 | Control read response (always OKAY) |
| irq | output | 1 | Level completion interrupt |
| mem_arvalid | output | 1 | Memory read request valid |
| mem_arready | input | 1 | Memory read request ready |
| mem_araddr | output | 32 | Memory read byte address |
| mem_arlen | output | 8 | Read burst length minus one |
| mem_arsize | output | 3 | Read beat size code |
| mem_arburst | output | 2 | Read burst type |
| mem_rvalid | input | 1 | Read data valid |
| mem_rready | output | 1 | Read data ready |
| mem_rdata | input | 32 | Read data |
| mem_rresp | input | 2 | Read response |
| mem_rlast | input | 1 | Last read beat |
| mem_awvalid | output | 1 | Memory write request valid |
| mem_awready | input | 1 | Memory write request ready |
| mem_awaddr | output | 32 | Memory write byte address |
| mem_awlen | output | 8 | Write burst length minus one |
| mem_awsize | output | 3 | Write beat size code |
| mem_awburst | output | 2 | Write burst type |
| mem_wvalid | output | 1 | Write data valid |
| mem_wready | input | 1 | Write data ready |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Write byte strobes |
| mem_wlast | output | 1 | Last write beat |
| mem_bvalid | input | 1 | Write response valid |
| mem_bready | output | 1 | Write response ready |
| mem_bresp | input | 2 | Write response |

## Verification
The collision of interest is the completion event, which sets done, and a control/status read, which clears done, landing on the same clock edge. The bench watches the memory side until it sees the write response handshake pending at the negative edge. In that same half cycle it raises the control read, so both handshakes happen at the next edge. It then checks three things: the colliding read returns the busy-only value, the following read returns done with idle, and a third read shows done cleared.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned VEC_LEN = 8;
    localparam int unsigned LANES   = 2;
    localparam int unsigned CFG_AW  = 6;

    localparam logic [CFG_AW-1:0] OFS_CTRL = 6'h00;
    localparam logic [CFG_AW-1:0] OFS_GATE = 6'h04;
    localparam logic [CFG_AW-1:0] OFS_IEN  = 6'h08;
    localparam logic [CFG_AW-1:0] OFS_IST  = 6'h0C;
    localparam logic [CFG_AW-1:0] OFS_BASA = 6'h10;
    localparam logic [CFG_AW-1:0] OFS_BASB = 6'h18;
    localparam logic [CFG_AW-1:0] OFS_BASR = 6'h20;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RADDR,
        PH_RDATA,
        PH_CALC,
        PH_WADDR,
        PH_WDATA,
        PH_WRESP
    } phase_e;
endpackage

// File: rtl/vmul_lane.sv
module vmul_lane #(
    parameter int unsigned DW = vmul_pkg::DATA_W
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] prod
);
    // Product truncated to the operand width by the assignment context.
    assign prod = op_a * op_b;
endmodule

// File: rtl/vmul_regs.sv
module vmul_regs
    import vmul_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned CAW = CFG_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_awvalid,
    output logic           cfg_awready,
    input  logic [CAW-1:0] cfg_awaddr,
    input  logic           cfg_wvalid,
    output logic           cfg_wready,
    input  logic [31:0]    cfg_wdata,
    input  logic [3:0]     cfg_wstrb,
    output logic           cfg_bvalid,
    input  logic           cfg_bready,
    input  logic           cfg_arvalid,
    output logic           cfg_arready,
    input  logic [CAW-1:0] cfg_araddr,
    output logic           cfg_rvalid,
    input  logic           cfg_rready,
    output logic [31:0]    cfg_rdata,
    output logic           irq,
    input  logic           busy_i,
    input  logic           fin_i,
    input  logic           err_i,
    output logic           start_o,
    output logic [AW-1:0]  base_a_o,
    output logic [AW-1:0]  base_b_o,
    output logic [AW-1:0]  base_r_o
);
    localparam int unsigned WW = AW - 2;

    typedef struct packed {
        logic          bvalid;
        logic          rvalid;
        logic [31:0]   rdata;
        logic          done;
        logic          gate;
        logic          ien;
        logic          ist;
        logic [WW-1:0] bas_a;
        logic [WW-1:0] bas_b;
        logic [WW-1:0] bas_r;
    } regs_t;

    regs_t       q, d;
    logic        wr_hs, rd_hs;
    logic [31:0] rd_mux;

    function automatic logic [WW-1:0] upd(input logic [WW-1:0] old,
                                          input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] t;
        t = {old, 2'b00};
        for (int b = 0; b < 4; b++) begin
            if (be[b]) t[b*8 +: 8] = nw[b*8 +: 8];
        end
        return t[31:2];
    endfunction

    always_comb begin
        unique case (cfg_araddr)
            OFS_CTRL: rd_mux = {28'd0, err_i, ~busy_i, q.done, busy_i};
            OFS_GATE: rd_mux = {31'd0, q.gate};
            OFS_IEN:  rd_mux = {31'd0, q.ien};
            OFS_IST:  rd_mux = {31'd0, q.ist};
            OFS_BASA: rd_mux = {q.bas_a, 2'b00};
            OFS_BASB: rd_mux = {q.bas_b, 2'b00};
            OFS_BASR: rd_mux = {q.bas_r, 2'b00};
            default:  rd_mux = 32'd0;
        endcase
    end

    always_comb begin
        d       = q;
        start_o = 1'b0;
        wr_hs   = cfg_awvalid & cfg_wvalid & ~q.bvalid;
        rd_hs   = cfg_arvalid & ~q.rvalid;

        if (q.bvalid && cfg_bready) d.bvalid = 1'b0;
        if (q.rvalid && cfg_rready) d.rvalid = 1'b0;

        if (rd_hs) begin
            d.rvalid = 1'b1;
            d.rdata  = rd_mux;
            if (cfg_araddr == OFS_CTRL) d.done = 1'b0;
        end

        if (wr_hs) begin
            d.bvalid = 1'b1;
            unique case (cfg_awaddr)
                OFS_CTRL: if (cfg_wstrb[0] && cfg_wdata[0] && !busy_i) begin
                    start_o = 1'b1;
                    d.done  = 1'b0;
                end
                OFS_GATE: if (cfg_wstrb[0]) d.gate = cfg_wdata[0];
                OFS_IEN:  if (cfg_wstrb[0]) d.ien  = cfg_wdata[0];
                OFS_IST:  if (cfg_wstrb[0] && cfg_wdata[0]) d.ist = 1'b0;
                OFS_BASA: d.bas_a = upd(q.bas_a, cfg_wdata, cfg_wstrb);
                OFS_BASB: d.bas_b = upd(q.bas_b, cfg_wdata, cfg_wstrb);
                OFS_BASR: d.bas_r = upd(q.bas_r, cfg_wdata, cfg_wstrb);
                default: ;
            endcase
        end

        // Completion is applied last so that setting wins over any clear.
        if (fin_i) begin
            d.done = 1'b1;
            if (q.ien) d.ist = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_awready = wr_hs;
    assign cfg_wready  = wr_hs;
    assign cfg_bvalid  = q.bvalid;
    assign cfg_arready = ~q.rvalid;
    assign cfg_rvalid  = q.rvalid;
    assign cfg_rdata   = q.rdata;
    assign irq         = q.gate & q.ist;
    assign base_a_o    = {q.bas_a, 2'b00};
    assign base_b_o    = {q.bas_b, 2'b00};
    assign base_r_o    = {q.bas_r, 2'b00};
endmodule

// File: rtl/vmul_engine.sv
module vmul_engine
    import vmul_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned N  = VEC_LEN,
    parameter int unsigned NL = LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_a_i,
    input  logic [AW-1:0] base_b_i,
    input  logic [AW-1:0] base_r_i,
    output logic          busy_o,
    output logic          fin_o,
    output logic          err_o,
    output logic          arvalid,
    input  logic          arready,
    output logic [AW-1:0] araddr,
    input  logic          rvalid,
    output logic          rready,
    input  logic [DW-1:0] rdata,
    input  logic [1:0]    rresp,
    input  logic          rlast,
    output logic          awvalid,
    input  logic          awready,
    output logic [AW-1:0] awaddr,
    output logic          wvalid,
    input  logic          wready,
    output logic [DW-1:0] wdata,
    output logic          wlast,
    input  logic          bvalid,
    output logic          bready,
    input  logic [1:0]    bresp
);
    localparam int unsigned IDXW  = $clog2(N);
    localparam int unsigned STEPS = N / NL;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N - 1);
    localparam logic [IDXW-1:0] LAST_STP = IDXW'(STEPS - 1);

    typedef struct packed {
        phase_e              ph;
        logic                src_b;
        logic [IDXW-1:0]     idx;
        logic                err;
        logic [N-1:0][DW-1:0] buf_a;
        logic [N-1:0][DW-1:0] buf_b;
        logic [N-1:0][DW-1:0] buf_r;
    } eng_t;

    eng_t q, d;

    logic [NL-1:0][DW-1:0] lane_a, lane_b, lane_p;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [IDXW-1:0] sel;
        assign sel       = IDXW'(int'(q.idx) * NL + l);
        assign lane_a[l] = q.buf_a[sel];
        assign lane_b[l] = q.buf_b[sel];
        vmul_lane #(.DW(DW)) u_lane (
            .op_a (lane_a[l]),
            .op_b (lane_b[l]),
            .prod (lane_p[l])
        );
    end

    always_comb begin
        d     = q;
        fin_o = 1'b0;
        unique case (q.ph)
            PH_IDLE: if (start_i) begin
                d.ph    = PH_RADDR;
                d.src_b = 1'b0;
                d.err   = 1'b0;
            end
            PH_RADDR: if (arready) begin
                d.ph  = PH_RDATA;
                d.idx = '0;
            end
            PH_RDATA: if (rvalid) begin
                if (q.src_b) d.buf_b[q.idx] = rdata;
                else         d.buf_a[q.idx] = rdata;
                if (rresp != 2'b00) d.err = 1'b1;
                d.idx = q.idx + 1'b1;
                if (q.idx == LAST_IDX || rlast) begin
                    d.idx = '0;
                    if (q.src_b) begin
                        d.ph = PH_CALC;
                    end else begin
                        d.ph    = PH_RADDR;
                        d.src_b = 1'b1;
                    end
                end
            end
            PH_CALC: begin
                for (int l = 0; l < NL; l++) begin
                    d.buf_r[IDXW'(int'(q.idx) * NL + l)] = lane_p[l];
                end
                d.idx = q.idx + 1'b1;
                if (q.idx == LAST_STP) begin
                    d.ph  = PH_WADDR;
                    d.idx = '0;
                end
            end
            PH_WADDR: if (awready) begin
                d.ph  = PH_WDATA;
                d.idx = '0;
            end
            PH_WDATA: if (wready) begin
                d.idx = q.idx + 1'b1;
                if (q.idx == LAST_IDX) d.ph = PH_WRESP;
            end
            PH_WRESP: if (bvalid) begin
                if (bresp != 2'b00) d.err = 1'b1;
                fin_o = 1'b1;
                d.ph  = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o  = (q.ph != PH_IDLE);
    assign err_o   = q.err;
    assign arvalid = (q.ph == PH_RADDR);
    assign araddr  = q.src_b ? base_b_i : base_a_i;
    assign rready  = (q.ph == PH_RDATA);
    assign awvalid = (q.ph == PH_WADDR);
    assign awaddr  = base_r_i;
    assign wvalid  = (q.ph == PH_WDATA);
    assign wdata   = q.buf_r[q.idx];
    assign wlast   = (q.ph == PH_WDATA) && (q.idx == LAST_IDX);
    assign bready  = (q.ph == PH_WRESP);
endmodule

// File: rtl/vmul_accel.sv
module vmul_accel
    import vmul_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_awvalid,
    output logic        cfg_awready,
    input  logic [5:0]  cfg_awaddr,
    input  logic        cfg_wvalid,
    output logic        cfg_wready,
    input  logic [31:0] cfg_wdata,
    input  logic [3:0]  cfg_wstrb,
    output logic        cfg_bvalid,
    input  logic        cfg_bready,
    output logic [1:0]  cfg_bresp,
    input  logic        cfg_arvalid,
    output logic        cfg_arready,
    input  logic [5:0]  cfg_araddr,
    output logic        cfg_rvalid,
    input  logic        cfg_rready,
    output logic [31:0] cfg_rdata,
    output logic [1:0]  cfg_rresp,
    output logic        irq,
    output logic        mem_arvalid,
    input  logic        mem_arready,
    output logic [31:0] mem_araddr,
    output logic [7:0]  mem_arlen,
    output logic [2:0]  mem_arsize,
    output logic [1:0]  mem_arburst,
    input  logic        mem_rvalid,
    output logic        mem_rready,
    input  logic [31:0] mem_rdata,
    input  logic [1:0]  mem_rresp,
    input  logic        mem_rlast,
    output logic        mem_awvalid,
    input  logic        mem_awready,
    output logic [31:0] mem_awaddr,
    output logic [7:0]  mem_awlen,
    output logic [2:0]  mem_awsize,
    output logic [1:0]  mem_awburst,
    output logic        mem_wvalid,
    input  logic        mem_wready,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_wstrb,
    output logic        mem_wlast,
    input  logic        mem_bvalid,
    output logic        mem_bready,
    input  logic [1:0]  mem_bresp
);
    localparam logic [7:0] BURST_LEN  = 8'(VEC_LEN - 1);
    localparam logic [2:0] BEAT_SIZE  = 3'($clog2(DATA_W / 8));
    localparam logic [1:0] BURST_INCR = 2'b01;

    logic              busy, fin, err, start;
    logic [ADDR_W-1:0] base_a, base_b, base_r;

    vmul_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_awvalid (cfg_awvalid),
        .cfg_awready (cfg_awready),
        .cfg_awaddr  (cfg_awaddr),
        .cfg_wvalid  (cfg_wvalid),
        .cfg_wready  (cfg_wready),
        .cfg_wdata   (cfg_wdata),
        .cfg_wstrb   (cfg_wstrb),
        .cfg_bvalid  (cfg_bvalid),
        .cfg_bready  (cfg_bready),
        .cfg_arvalid (cfg_arvalid),
        .cfg_arready (cfg_arready),
        .cfg_araddr  (cfg_araddr),
        .cfg_rvalid  (cfg_rvalid),
        .cfg_rready  (cfg_rready),
        .cfg_rdata   (cfg_rdata),
        .irq         (irq),
        .busy_i      (busy),
        .fin_i       (fin),
        .err_i       (err),
        .start_o     (start),
        .base_a_o    (base_a),
        .base_b_o    (base_b),
        .base_r_o    (base_r)
    );

    vmul_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .base_a_i (base_a),
        .base_b_i (base_b),
        .base_r_i (base_r),
        .busy_o   (busy),
        .fin_o    (fin),
        .err_o    (err),
        .arvalid  (mem_arvalid),
        .arready  (mem_arready),
        .araddr   (mem_araddr),
        .rvalid   (mem_rvalid),
        .rready   (mem_rready),
        .rdata    (mem_rdata),
        .rresp    (mem_rresp),
        .rlast    (mem_rlast),
        .awvalid  (mem_awvalid),
        .awready  (mem_awready),
        .awaddr   (mem_awaddr),
        .wvalid   (mem_wvalid),
        .wready   (mem_wready),
        .wdata    (mem_wdata),
        .wlast    (mem_wlast),
        .bvalid   (mem_bvalid),
        .bready   (mem_bready),
        .bresp    (mem_bresp)
    );

    assign cfg_bresp   = 2'b00;
    assign cfg_rresp   = 2'b00;
    assign mem_arlen   = BURST_LEN;
    assign mem_arsize  = BEAT_SIZE;
    assign mem_arburst = BURST_INCR;
    assign mem_awlen   = BURST_LEN;
    assign mem_awsize  = BEAT_SIZE;
    assign mem_awburst = BURST_INCR;
    assign mem_wstrb   = {(DATA_W / 8){1'b1}};
endmodule

// File: rtl/vmul_accel_chk.sv
module vmul_accel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_arvalid,
    input logic        mem_arready,
    input logic [31:0] mem_araddr,
    input logic [7:0]  mem_arlen,
    input logic [2:0]  mem_arsize,
    input logic [1:0]  mem_arburst,
    input logic        mem_awvalid,
    input logic        mem_wvalid,
    input logic        mem_wready,
    input logic [31:0] mem_wdata,
    input logic [3:0]  mem_wstrb,
    input logic        mem_wlast
);
    AST_AR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_arvalid |-> (mem_arlen == 8'd7 && mem_arsize == 3'd2 && mem_arburst == 2'b01
                         && mem_araddr[1:0] == 2'b00)); // R3
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_arvalid && !mem_arready) |=> (mem_arvalid && $stable(mem_araddr))); // R3
    AST_W_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> (mem_wstrb == 4'hF)); // R4
    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_wdata))); // R4
    AST_WLAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wlast |-> mem_wvalid); // R4
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_arvalid && (mem_awvalid || mem_wvalid))); // R2
endmodule

bind vmul_accel vmul_accel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_arvalid (mem_arvalid),
    .mem_arready (mem_arready),
    .mem_araddr  (mem_araddr),
    .mem_arlen   (mem_arlen),
    .mem_arsize  (mem_arsize),
    .mem_arburst (mem_arburst),
    .mem_awvalid (mem_awvalid),
    .mem_wvalid  (mem_wvalid),
    .mem_wready  (mem_wready),
    .mem_wdata   (mem_wdata),
    .mem_wstrb   (mem_wstrb),
    .mem_wlast   (mem_wlast)
);

// File: tb/vmul_accel_bench.sv
`timescale 1ns/1ps
module vmul_accel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_awvalid = 0, cfg_wvalid = 0, cfg_arvalid = 0;
    logic [5:0]  cfg_awaddr = 0, cfg_araddr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [3:0]  cfg_wstrb = 0;
    logic        cfg_awready, cfg_wready, cfg_bvalid, cfg_arready, cfg_rvalid;
    logic [1:0]  cfg_bresp, cfg_rresp;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        mem_arvalid, mem_arready, mem_rvalid, mem_rready, mem_rlast;
    logic [31:0] mem_araddr, mem_rdata, mem_awaddr, mem_wdata;
    logic [7:0]  mem_arlen, mem_awlen;
    logic [2:0]  mem_arsize, mem_awsize;
    logic [1:0]  mem_arburst, mem_awburst, mem_rresp, mem_bresp;
    logic        mem_awvalid, mem_awready, mem_wvalid, mem_wready, mem_wlast;
    logic [3:0]  mem_wstrb;
    logic        mem_bvalid, mem_bready;

    always #2 clk = ~clk;

    vmul_accel u_vmul_accel (
        .clk(clk), .rst_n(rst_n),
        .cfg_awvalid(cfg_awvalid), .cfg_awready(cfg_awready), .cfg_awaddr(cfg_awaddr),
        .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready), .cfg_wdata(cfg_wdata),
        .cfg_wstrb(cfg_wstrb), .cfg_bvalid(cfg_bvalid), .cfg_bready(1'b1),
        .cfg_bresp(cfg_bresp), .cfg_arvalid(cfg_arvalid), .cfg_arready(cfg_arready),
        .cfg_araddr(cfg_araddr), .cfg_rvalid(cfg_rvalid), .cfg_rready(1'b1),
        .cfg_rdata(cfg_rdata), .cfg_rresp(cfg_rresp), .irq(irq),
        .mem_arvalid(mem_arvalid), .mem_arready(mem_arready), .mem_araddr(mem_araddr),
        .mem_arlen(mem_arlen), .mem_arsize(mem_arsize), .mem_arburst(mem_arburst),
        .mem_rvalid(mem_rvalid), .mem_rready(mem_rready), .mem_rdata(mem_rdata),
        .mem_rresp(mem_rresp), .mem_rlast(mem_rlast),
        .mem_awvalid(mem_awvalid), .mem_awready(mem_awready), .mem_awaddr(mem_awaddr),
        .mem_awlen(mem_awlen), .mem_awsize(mem_awsize), .mem_awburst(mem_awburst),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb), .mem_wlast(mem_wlast),
        .mem_bvalid(mem_bvalid), .mem_bready(mem_bready), .mem_bresp(mem_bresp)
    );

    // ---------------- behavioural memory ----------------
    logic [31:0] mem [64];
    logic        rd_act = 0, b_pend = 0;
    logic [5:0]  rd_ptr = 0, wr_ptr = 0;
    logic [3:0]  rd_cnt = 0, w_beat = 0;
    logic [1:0]  rresp_inj = 0, bresp_inj = 0;
    int          ar_cnt = 0, aw_cnt = 0, cyc = 0, last_r_cyc = 0, aw_cyc = 0;
    logic [31:0] ar_log [4];
    logic [31:0] aw_log = 0;
    logic        fmt_bad = 0, w_bad = 0;

    assign mem_arready = !rd_act;
    assign mem_rvalid  = rd_act;
    assign mem_rdata   = mem[rd_ptr];
    assign mem_rlast   = rd_act && (rd_cnt == 4'd7);
    assign mem_rresp   = rresp_inj;
    assign mem_awready = 1'b1;
    assign mem_wready  = 1'b1;
    assign mem_bvalid  = b_pend;
    assign mem_bresp   = bresp_inj;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_arvalid && mem_arready) begin
            rd_act <= 1'b1; rd_ptr <= mem_araddr[7:2]; rd_cnt <= 0;
            ar_log[ar_cnt % 4] <= mem_araddr; ar_cnt <= ar_cnt + 1;
            if (mem_arlen != 8'd7 || mem_arsize != 3'd2 || mem_arburst != 2'b01) fmt_bad <= 1'b1;
        end
        if (mem_rvalid && mem_rready) begin
            rd_ptr <= rd_ptr + 1; rd_cnt <= rd_cnt + 1;
            if (rd_cnt == 4'd7) begin rd_act <= 1'b0; last_r_cyc <= cyc; end
        end
        if (mem_awvalid && mem_awready) begin
            wr_ptr <= mem_awaddr[7:2]; aw_log <= mem_awaddr; aw_cnt <= aw_cnt + 1;
            aw_cyc <= cyc; w_beat <= 0;
            if (mem_awlen != 8'd7 || mem_awsize != 3'd2 || mem_awburst != 2'b01) w_bad <= 1'b1;
        end
        if (mem_wvalid && mem_wready) begin
            mem[wr_ptr] <= mem_wdata; wr_ptr <= wr_ptr + 1; w_beat <= w_beat + 1;
            if (mem_wstrb != 4'hF || mem_wlast != (w_beat == 4'd7)) w_bad <= 1'b1;
            if (mem_wlast) b_pend <= 1'b1;
        end
        if (mem_bvalid && mem_bready) b_pend <= 1'b0;
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [31:0] v, input logic [3:0] s);
        @(negedge clk);
        cfg_awvalid = 1; cfg_wvalid = 1; cfg_awaddr = a; cfg_wdata = v; cfg_wstrb = s;
        while (!cfg_awready) @(negedge clk);
        @(negedge clk);
        cfg_awvalid = 0; cfg_wvalid = 0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_arvalid = 1; cfg_araddr = a;
        while (!cfg_arready) @(negedge clk);
        @(negedge clk);
        cfg_arvalid = 0; v = cfg_rdata;
    endtask

    task automatic wait_done(output logic [31:0] st);
        st = 0;
        for (int k = 0; k < 400; k++) begin
            cfg_read(6'h00, st);
            if (st[1]) break;
        end
    endtask

    task automatic load_vectors(input int seed);
        for (int i = 0; i < 8; i++) begin
            mem[i]      = 32'h1000_0001 * (i + 1) + seed;
            mem[16 + i] = 32'hFFFF_FFF0 + i * 3 + seed;
            mem[32 + i] = 32'hDEAD_0000;
        end
        mem[0] = 32'hFFFF_FFFF; mem[16] = 32'hFFFF_FFFF;
        mem[1] = 32'h0001_0000; mem[17] = 32'h0001_0000;
    endtask

    task automatic check_results(input string tag);
        logic [31:0] e;
        for (int i = 0; i < 8; i++) begin
            e = mem[i] * mem[16 + i];
            chk(tag, mem[32 + i], e);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 arvalid", {31'd0, mem_arvalid}, 0);
        chk("R1 awvalid", {31'd0, mem_awvalid}, 0);
        cfg_read(6'h00, v);
        chk("R1 ctrl", v, 32'h4);
    endtask

    task automatic t_bases;
        logic [31:0] v;
        cfg_write(6'h10, 32'hFFFF_FFFF, 4'h1);
        cfg_read(6'h10, v);
        chk("R11 strobe", v, 32'h0000_00FC);
        cfg_write(6'h10, 32'h0000_0003, 4'hF);
        cfg_write(6'h18, 32'h0000_0041, 4'hF);
        cfg_write(6'h20, 32'h0000_0082, 4'hF);
        cfg_read(6'h10, v); chk("R11 base a", v, 32'h0);
        cfg_read(6'h18, v); chk("R11 base b", v, 32'h40);
        cfg_read(6'h20, v); chk("R11 base r", v, 32'h80);
    endtask

    task automatic t_basic;
        logic [31:0] v, a0;
        int ar0, aw0;
        load_vectors(0);
        a0 = mem[3];
        ar0 = ar_cnt; aw0 = aw_cnt;
        cfg_write(6'h04, 1, 4'hF);
        cfg_write(6'h08, 1, 4'hF);
        cfg_write(6'h00, 1, 4'h1);
        wait_done(v);
        chk("R5 done status", v, 32'h6);
        check_results("R2 product");
        chk("R2 operand kept", mem[3], a0);
        chk("R3 ar count", ar_cnt - ar0, 2);
        chk("R3 first addr", ar_log[ar0 % 4], 32'h00);
        chk("R3 second addr", ar_log[(ar0 + 1) % 4], 32'h40);
        chk("R3 format", {31'd0, fmt_bad}, 0);
        chk("R4 aw count", aw_cnt - aw0, 1);
        chk("R4 aw addr", aw_log, 32'h80);
        chk("R4 beats", {31'd0, w_bad}, 0);
        chk("R12 compute gap", aw_cyc - last_r_cyc, 5);
        cfg_read(6'h00, v);
        chk("R5 done cleared", v, 32'h4);
        chk("R8 irq set", {31'd0, irq}, 1);
        cfg_write(6'h04, 0, 4'hF);
        @(negedge clk);
        chk("R8 gate off", {31'd0, irq}, 0);
        cfg_write(6'h04, 1, 4'hF);
        cfg_write(6'h0C, 1, 4'hF);
        @(negedge clk);
        chk("R8 cleared", {31'd0, irq}, 0);
    endtask

    task automatic t_busy_start;
        logic [31:0] v;
        int ar0, aw0;
        load_vectors(5);
        ar0 = ar_cnt; aw0 = aw_cnt;
        cfg_write(6'h00, 1, 4'h1);
        cfg_write(6'h00, 1, 4'h1);
        cfg_write(6'h00, 1, 4'h1);
        wait_done(v);
        repeat (60) @(negedge clk);
        chk("R6 ar count", ar_cnt - ar0, 2);
        chk("R6 aw count", aw_cnt - aw0, 1);
        check_results("R6 product");
    endtask

    task automatic t_autorestart;
        logic [31:0] v;
        int ar0;
        load_vectors(9);
        ar0 = ar_cnt;
        cfg_write(6'h00, 32'h81, 4'h1);
        wait_done(v);
        chk("R7 bit7 reads 0", {31'd0, v[7]}, 0);
        repeat (60) @(negedge clk);
        chk("R7 single run", ar_cnt - ar0, 2);
        check_results("R7 product");
    endtask

    task automatic t_errors;
        logic [31:0] v;
        load_vectors(2);
        rresp_inj = 2'b10;
        cfg_write(6'h00, 1, 4'h1);
        wait_done(v);
        rresp_inj = 2'b00;
        chk("R9 read error", v, 32'hE);
        load_vectors(3);
        cfg_write(6'h00, 1, 4'h1);
        wait_done(v);
        chk("R9 error cleared", v, 32'h6);
        load_vectors(4);
        bresp_inj = 2'b11;
        cfg_write(6'h00, 1, 4'h1);
        wait_done(v);
        bresp_inj = 2'b00;
        chk("R9 write error", v, 32'hE);
        check_results("R9 data moved");
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        load_vectors(7);
        cfg_write(6'h0C, 1, 4'hF);
        cfg_write(6'h00, 1, 4'h1);
        @(negedge clk);
        for (int k = 0; k < 400; k++) begin
            if (mem_bvalid && mem_bready) break;
            @(negedge clk);
        end
        chk("R10 arready at collision", {31'd0, cfg_arready}, 1);
        cfg_arvalid = 1; cfg_araddr = 6'h00;
        @(negedge clk);
        cfg_arvalid = 0; v = cfg_rdata;
        chk("R10 colliding read", v, 32'h1);
        cfg_read(6'h00, v);
        chk("R10 done kept", v, 32'h6);
        cfg_read(6'h00, v);
        chk("R5 clear on read", v, 32'h4);
        chk("R8 irq at collision", {31'd0, irq}, 1);
        check_results("R10 product");
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bases();
        t_basic();
        t_busy_start();
        t_autorestart();
        t_errors();
        t_same_cycle();
        report();
    end
endmodule